// File: doc/BRIEF.md
# Programmable Bitwise Logic Unit

This block applies one of the sixteen Boolean functions of two inputs, bit by bit, to a pair of equal-width operands. The function is not chosen by a decoded opcode: the caller supplies its four-entry truth table directly as a 4-bit code. Every result bit looks up that table, using its own pair of operand bits as the index. The same code can therefore express AND, OR, XOR, NAND, pass-through of either operand, inversion, the two inhibitions and implications, and the two constants, with no decode logic in between.

The unit is purely combinational and sits inside an execution datapath. An enable input gates the whole result: when the unit is not selected, it drives all zeros, so that its output can be OR-combined with the results of other functional units. The width is a parameter and defaults to 32 bits.

Table index convention: bit `k` of the function code is the result for an operand pair where `k = 2*a + b`. So `fn[0]` gives the result for a=0,b=0, `fn[1]` for a=0,b=1, `fn[2]` for a=1,b=0, and `fn[3]` for a=1,b=1.

Top module: `bitwise_logic_unit`

## Requirements
- R1: With `en`=1, every result bit `res[i]` equals `fn[2*a[i] + b[i]]`.
- R2: Code 4'hE (fn[0]=0, the rest 1) gives the bitwise OR of `a` and `b`.
- R3: Code 4'h7 (fn[3]=0, the rest 1) gives the bitwise NAND of `a` and `b`.
- R4: Code 4'h0 drives every result bit to 0, and code 4'hF drives every result bit to 1, whatever the operands.
- R5: With `en`=0, `res` is all zeros for any `a`, `b` and `fn`.
- R6: Code 4'hC passes `a` through unchanged and code 4'hA passes `b` through unchanged.
- R7: Each result bit depends only on the operand bits at the same position: a change in `a[j]` or `b[j]` leaves every other result bit unchanged.
- R8: Code 4'h8 gives bitwise AND and code 4'h6 gives bitwise XOR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand; its bit forms the upper half of each table index |
| b | input | WIDTH | Second operand; its bit forms the lower half of each table index |
| fn | input | 4 | Truth table of the selected function, indexed by {a,b} |
| en | input | 1 | 1 activates the unit, 0 forces the result to zero |
| res | output | WIDTH | Bitwise result |

## Verification
The hardest situation to reach is one where a single table entry is used at some bit positions and not others, because a fault that swaps or drops one multiplexer input only shows when the operand pair at some bit hits that exact index with a distinguishing table value. The stimulus sweeps all sixteen codes, and for each one applies random operand pairs of full width, which with 32 bits hits all four index values in nearly every vector. Single-bit flips of one operand then confirm that neighbouring result bits stay fixed.

// File: rtl/blu_pkg.sv
package blu_pkg;

    // Function codes; bit k is the result for operand pair index k = {a,b}.
    localparam logic [3:0] FN_ZERO  = 4'h0;
    localparam logic [3:0] FN_AND   = 4'h8;
    localparam logic [3:0] FN_XOR   = 4'h6;
    localparam logic [3:0] FN_OR    = 4'hE;
    localparam logic [3:0] FN_NAND  = 4'h7;
    localparam logic [3:0] FN_PASSA = 4'hC;
    localparam logic [3:0] FN_PASSB = 4'hA;
    localparam logic [3:0] FN_ONES  = 4'hF;

    // Operand bit pair that selects one table entry.
    typedef struct packed {
        logic hi;   // bit from operand a
        logic lo;   // bit from operand b
    } sel_pair_t;

    typedef enum logic [1:0] {
        IDX_A0B0 = 2'd0,
        IDX_A0B1 = 2'd1,
        IDX_A1B0 = 2'd2,
        IDX_A1B1 = 2'd3
    } tbl_idx_t;

    function automatic tbl_idx_t pair_to_idx(input sel_pair_t p);
        return tbl_idx_t'({p.hi, p.lo});
    endfunction

endpackage

// File: rtl/blu_slice.sv
module blu_slice
    import blu_pkg::*;
(
    input  logic [3:0] tbl,
    input  sel_pair_t  sel,
    output logic       y
);

    tbl_idx_t idx;

    always_comb begin
        idx = pair_to_idx(sel);
        unique case (idx)
            IDX_A0B0: y = tbl[0];
            IDX_A0B1: y = tbl[1];
            IDX_A1B0: y = tbl[2];
            IDX_A1B1: y = tbl[3];
            default:  y = 1'b0;
        endcase
    end

endmodule

// File: rtl/blu_array.sv
module blu_array
    import blu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [3:0]       tbl,
    output logic [WIDTH-1:0] raw
);

    sel_pair_t [WIDTH-1:0] pairs;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        assign pairs[i].hi = opa[i];
        assign pairs[i].lo = opb[i];

        blu_slice u_slice (
            .tbl (tbl),
            .sel (pairs[i]),
            .y   (raw[i])
        );
    end

endmodule

// File: rtl/blu_gate.sv
module blu_gate #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] din,
    input  logic             en,
    output logic [WIDTH-1:0] dout
);

    localparam logic [WIDTH-1:0] ALL_ZERO = '0;

    always_comb begin
        dout = en ? din : ALL_ZERO;
    end

endmodule

// File: rtl/bitwise_logic_unit.sv
module bitwise_logic_unit
    import blu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       fn,
    input  logic             en,
    output logic [WIDTH-1:0] res
);

    localparam logic [WIDTH-1:0] ONES = '1;

    logic [WIDTH-1:0] raw;

    blu_array #(.WIDTH(WIDTH)) u_array (
        .opa (a),
        .opb (b),
        .tbl (fn),
        .raw (raw)
    );

    blu_gate #(.WIDTH(WIDTH)) u_gate (
        .din  (raw),
        .en   (en),
        .dout (res)
    );

    always_comb begin
        if (!$isunknown({a, b, fn, en})) begin
            // R5
            r5_off_chk: assert (en || res == '0);
            // R4
            r4_zero_chk: assert (!(en && fn == FN_ZERO) || res == '0);
            // R4
            r4_ones_chk: assert (!(en && fn == FN_ONES) || res == ONES);
            // R2
            r2_or_chk: assert (!(en && fn == FN_OR) || res == (a | b));
            // R3
            r3_nand_chk: assert (!(en && fn == FN_NAND) || res == ~(a & b));
            // R6
            r6_pass_chk: assert (!(en && fn == FN_PASSA) || res == a);
            // R8
            r8_xor_chk: assert (!(en && fn == FN_XOR) || res == (a ^ b));
        end
    end

endmodule

// File: tb/sim_bitwise_logic_unit.sv
module sim_bitwise_logic_unit;

    localparam int W          = 32;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 50000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a   = '0;
    logic [W-1:0] b   = '0;
    logic [3:0]   fn  = '0;
    logic         en  = 1'b0;
    logic [W-1:0] res;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    bitwise_logic_unit #(.WIDTH(W)) u0 (
        .a   (a),
        .b   (b),
        .fn  (fn),
        .en  (en),
        .res (res)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WD_LIMIT && !done) begin
            errors = errors + 1;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Reference built from the table-index rule of R1 and the gating of R5.
    function automatic logic [W-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic [3:0] f, input logic e);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            int k;
            k = (x[i] ? 2 : 0) + (y[i] ? 1 : 0);
            r[i] = f[k];
        end
        return e ? r : '0;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h (a=%h b=%h fn=%h en=%b)",
                     req, act, exp, a, b, fn, en);
        end
    endtask

    task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y,
                         input logic [3:0] f, input logic e);
        @(posedge clk);
        a  = x;
        b  = y;
        fn = f;
        en = e;
        @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] x, y, base;
        void'($urandom(32'd2024));

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R5: reset state with the unit disabled
        check("R5 reset", res, '0);
        rst = 1'b0;

        // R2 OR
        x = 32'h0000_001E; y = 32'h0000_0098;
        apply(x, y, 4'hE, 1'b1);
        check("R2 or", res, 32'h0000_009E);
        // R8 AND
        apply(x, y, 4'h8, 1'b1);
        check("R8 and", res, 32'h0000_0018);
        // R8 XOR
        apply(32'hF0F0_A5A5, 32'hFF00_5AA5, 4'h6, 1'b1);
        check("R8 xor", res, 32'h0FF0_FF00);
        // R3 NAND
        apply(32'hCAFE_0000, 32'hFFFF_FFFF, 4'h7, 1'b1);
        check("R3 nand", res, 32'h3501_FFFF);
        // R4 constants
        apply(32'hFFFF_FFFF, 32'h1234_5678, 4'h0, 1'b1);
        check("R4 zero", res, 32'h0);
        apply(32'h0, 32'h0, 4'hF, 1'b1);
        check("R4 ones", res, 32'hFFFF_FFFF);
        // R6 pass-through
        x = $urandom(); y = $urandom();
        apply(x, y, 4'hC, 1'b1);
        check("R6 pass a", res, x);
        apply(x, y, 4'hA, 1'b1);
        check("R6 pass b", res, y);
        // R5 disabled with all-ones code
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'hF, 1'b0);
        check("R5 disabled ones", res, 32'h0);

        // R1 sweep of all codes with random operands and occasional disable
        for (int f = 0; f < 16; f++) begin
            for (int n = 0; n < 24; n++) begin
                logic e;
                x = $urandom(); y = $urandom();
                e = ($urandom_range(0, 7) != 0);
                apply(x, y, 4'(f), e);
                check(e ? "R1 sweep" : "R5 sweep", res, model(x, y, 4'(f), e));
            end
        end

        // R7 single-bit flips keep neighbour bits fixed
        for (int n = 0; n < 40; n++) begin
            logic [3:0] f;
            logic [W-1:0] r0;
            int j;
            f = 4'($urandom_range(0, 15));
            base = $urandom(); y = $urandom();
            j = $urandom_range(0, W-1);
            apply(base, y, f, 1'b1);
            r0 = res;
            apply(base ^ (32'h1 << j), y, f, 1'b1);
            check("R7 isolation a", res & ~(32'h1 << j), r0 & ~(32'h1 << j));
            apply(base, y ^ (32'h1 << j), f, 1'b1);
            check("R7 isolation b", res & ~(32'h1 << j), r0 & ~(32'h1 << j));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule